// File: doc/BRIEF.md
# Multi-Socket Temperature Register Bank

This block is the storage and decode layer that sits behind a two-wire serial slave in a thermal-monitoring bridge. The serial front end frames the bus traffic and hands the bank one command at a time: a word read, a word write, or a send-byte with no data. A separate polling engine supplies fresh temperature samples. Each sample is tagged with a socket (four of them) and a domain (two per socket). The bank adds the configured signed offset to each sample before it stores it.

Beyond plain storage, the bank keeps a registered maximum over every enabled socket, together with the code of the entry that holds it. It also latches a sticky alert when an enabled temperature rises above the threshold of its socket, and records which entry caused that alert. Two send-byte commands control activity around the bank. One raises a single-cycle poll-request strobe toward the polling engine. The other clears the alert.

Top module: `thermo_regbank`

## Requirements
- R1: A word read (op 0) of code 00h..07h returns the stored temperature of socket = code/2, domain = code%2. A read answers on rd_data with rd_valid high for exactly the one cycle after the command cycle.
- R2: A temperature update stores update value + offset, where the offset is the signed word at code 0Eh. The sum wraps modulo 2^16.
- R3: Code 08h reads the signed maximum over all entries whose socket is enabled. When no socket is enabled it reads 0000h.
- R4: Code 0Ah reads the entry code (2*socket+domain) of that maximum, taking the lowest code on a tie. It reads 0000h when no socket is enabled.
- R5: Codes 0Ch..0Fh are read/write configuration words (op 1 = write). In word 0Ch, bit n enables socket n (bits 3:0), bit 4 is the bus-timeout enable, bit 5 is the PEC enable, bit 6 is the alert enable, and bits 15:8 are the polling delay. After reset, 0Ch reads 000Fh and 0Dh..0Fh read 0000h.
- R6: Codes 10h..13h are read/write alert thresholds for sockets 0..3, each 7FFFh after reset.
- R7: When the alert enable is set and any enabled temperature is signed-greater than its socket's threshold, the alert output sets. It stays set even after the temperature falls, until send-byte (op 2) code 15h clears it.
- R8: Code 0Bh reads the entry code of the lowest-coded offending entry at the moment the alert set. It reads 0000h while the alert is clear.
- R9: Send-byte code 14h drives poll_req high for exactly the one cycle after the command. No other command raises it.
- R10: Code 09h reads the firmware version parameter (default 0103h). Writes to codes 00h..0Bh and 14h and above change nothing. Reads of codes 14h and above return 0000h.
- R11: After reset, rd_data, rd_valid, alert and poll_req are 0 and all temperatures read 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 0 word read, 1 word write, 2 send-byte |
| cmd_code | input | 8 | Command code |
| cmd_wdata | input | 16 | Write word |
| upd_valid | input | 1 | Temperature sample presented |
| upd_sock | input | 2 | Sample socket |
| upd_dom | input | 1 | Sample domain |
| upd_temp | input | 16 | Signed raw sample |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | rd_data holds a fresh result |
| alert | output | 1 | Sticky over-threshold flag |
| poll_req | output | 1 | One-cycle polling request |

## Verification
The bench targets signed comparison, using samples and thresholds on both sides of zero. A design that compared unsigned would report a negative reading as the maximum or would raise a false alert. It disables every socket, where a design lacking the zero rule would return a stale or most-negative maximum. It makes equal readings tie, where a design choosing the wrong entry would report the higher code. It lowers a temperature after an alert to show the flag stays set, and it writes to read-only codes and reads undefined ones to expose decode leaks. It also checks that reading code 14h does not fire the poll strobe.

// File: rtl/tbank_pkg.sv
package tbank_pkg;
  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_WR   = 2'd1,
    OP_SEND = 2'd2,
    OP_NONE = 2'd3
  } tb_op_e;

  localparam logic [7:0] C_MAX     = 8'h08;
  localparam logic [7:0] C_FW      = 8'h09;
  localparam logic [7:0] C_MAXLOC  = 8'h0A;
  localparam logic [7:0] C_ALOC    = 8'h0B;
  localparam logic [7:0] C_CFG0    = 8'h0C;
  localparam logic [7:0] C_THR0    = 8'h10;
  localparam logic [7:0] C_POLL    = 8'h14;
  localparam logic [7:0] C_CLR     = 8'h15;

  localparam int CFG_TMO_BIT   = 4;
  localparam int CFG_PEC_BIT   = 5;
  localparam int CFG_ALERT_BIT = 6;
endpackage

// File: rtl/tbank_temp_store.sv
module tbank_temp_store #(
  parameter int NENT = 8,
  parameter int DW   = 16,
  parameter int IW   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [DW-1:0]            wr_val,
  input  logic [DW-1:0]            offset,
  output logic [NENT-1:0][DW-1:0]  temps
);
  logic [DW-1:0] adj;
  assign adj = wr_val + offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      temps <= '0;
    end else if (wr_en && (int'(wr_idx) < NENT)) begin
      temps[wr_idx] <= adj;
    end
  end

  assert_store_offset_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (int'(wr_idx) < NENT)) |=> (temps[$past(wr_idx)] == $past(wr_val) + $past(offset)));
endmodule

// File: rtl/tbank_max_find.sv
module tbank_max_find #(
  parameter int NSOCK = 4,
  parameter int NDOM  = 2,
  parameter int DW    = 16,
  parameter int IW    = 3,
  localparam int NENT = NSOCK * NDOM
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NENT-1:0][DW-1:0]  temps,
  input  logic [NSOCK-1:0]         sock_en,
  output logic [DW-1:0]            mx_q,
  output logic [IW-1:0]            mx_loc_q
);
  logic [DW-1:0] best;
  logic [IW-1:0] best_loc;
  logic          found;

  always_comb begin
    best     = '0;
    best_loc = '0;
    found    = 1'b0;
    for (int i = 0; i < NENT; i++) begin
      if (sock_en[i / NDOM]) begin
        if (!found || ($signed(temps[i]) > $signed(best))) begin
          best     = temps[i];
          best_loc = IW'(i);
        end
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mx_q     <= '0;
      mx_loc_q <= '0;
    end else begin
      mx_q     <= best;
      mx_loc_q <= best_loc;
    end
  end

  // R3 / R4: nothing enabled gives zero value and zero location
  assert_none_enabled_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (sock_en == '0) |=> (mx_q == '0 && mx_loc_q == '0));
  // R3: the reported maximum is never below an enabled entry of the previous cycle
  assert_max_dominates_R3: assert property (@(posedge clk) disable iff (rst)
    (sock_en[0]) |=> ($signed(mx_q) >= $signed($past(temps[0]))));
endmodule

// File: rtl/tbank_alert_latch.sv
module tbank_alert_latch #(
  parameter int NSOCK = 4,
  parameter int NDOM  = 2,
  parameter int DW    = 16,
  parameter int IW    = 3,
  localparam int NENT = NSOCK * NDOM
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NENT-1:0][DW-1:0]  temps,
  input  logic [NSOCK-1:0][DW-1:0] thr,
  input  logic [NSOCK-1:0]         sock_en,
  input  logic                     alert_en,
  input  logic                     clr,
  output logic                     alert_q,
  output logic [IW-1:0]            loc_q
);
  logic          hit;
  logic [IW-1:0] hit_loc;

  always_comb begin
    hit     = 1'b0;
    hit_loc = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (sock_en[i / NDOM] && ($signed(temps[i]) > $signed(thr[i / NDOM]))) begin
        hit     = 1'b1;
        hit_loc = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      alert_q <= 1'b0;
      loc_q   <= '0;
    end else if (!alert_q && alert_en && hit) begin
      alert_q <= 1'b1;
      loc_q   <= hit_loc;
    end
  end

  assert_alert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (alert_q && !clr) |=> alert_q);
  assert_alert_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_q) |-> $past(alert_en));
  assert_loc_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (alert_q && !clr) |=> $stable(loc_q));
endmodule

// File: rtl/thermo_regbank.sv
module thermo_regbank
  import tbank_pkg::*;
#(
  parameter int            NSOCK  = 4,
  parameter int            NDOM   = 2,
  parameter int            DW     = 16,
  parameter logic [15:0]   FW_VER = 16'h0103,
  localparam int           NENT   = NSOCK * NDOM,
  localparam int           IW     = $clog2(NENT),
  localparam int           SW     = $clog2(NSOCK),
  localparam int           DMW    = (NDOM > 1) ? $clog2(NDOM) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [7:0]      cmd_code,
  input  logic [DW-1:0]   cmd_wdata,
  input  logic            upd_valid,
  input  logic [SW-1:0]   upd_sock,
  input  logic [DMW-1:0]  upd_dom,
  input  logic [DW-1:0]   upd_temp,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic            alert,
  output logic            poll_req
);
  tb_op_e op;
  assign op = tb_op_e'(cmd_op);

  logic [3:0][DW-1:0]      cfg;
  logic [NSOCK-1:0][DW-1:0] thr;
  logic [NENT-1:0][DW-1:0]  temps;
  logic [DW-1:0]            mx_q;
  logic [IW-1:0]            mx_loc_q;
  logic [IW-1:0]            aloc_q;
  logic [IW-1:0]            upd_idx;
  logic                     is_rd, is_wr, is_send;
  logic                     wr_cfg, wr_thr;
  logic [DW-1:0]            rd_mux;

  assign is_rd   = cmd_valid && (op == OP_RD);
  assign is_wr   = cmd_valid && (op == OP_WR);
  assign is_send = cmd_valid && (op == OP_SEND);
  assign wr_cfg  = is_wr && (cmd_code[7:2] == C_CFG0[7:2]);
  assign wr_thr  = is_wr && (cmd_code >= C_THR0) && (int'(cmd_code - C_THR0) < NSOCK);
  assign upd_idx = IW'(int'(upd_sock) * NDOM + int'(upd_dom));

  tbank_temp_store #(.NENT(NENT), .DW(DW), .IW(IW)) u_store (
    .clk(clk), .rst(rst), .wr_en(upd_valid), .wr_idx(upd_idx),
    .wr_val(upd_temp), .offset(cfg[2]), .temps(temps)
  );

  tbank_max_find #(.NSOCK(NSOCK), .NDOM(NDOM), .DW(DW), .IW(IW)) u_max (
    .clk(clk), .rst(rst), .temps(temps), .sock_en(cfg[0][NSOCK-1:0]),
    .mx_q(mx_q), .mx_loc_q(mx_loc_q)
  );

  tbank_alert_latch #(.NSOCK(NSOCK), .NDOM(NDOM), .DW(DW), .IW(IW)) u_alert (
    .clk(clk), .rst(rst), .temps(temps), .thr(thr),
    .sock_en(cfg[0][NSOCK-1:0]), .alert_en(cfg[0][CFG_ALERT_BIT]),
    .clr(is_send && (cmd_code == C_CLR)), .alert_q(alert), .loc_q(aloc_q)
  );

  // configuration and thresholds
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      cfg[0] <= DW'((1 << NSOCK) - 1);
      for (int s = 0; s < NSOCK; s++) thr[s] <= {1'b0, {(DW-1){1'b1}}};
    end else begin
      if (wr_cfg) cfg[cmd_code[1:0]] <= cmd_wdata;
      if (wr_thr) thr[cmd_code[SW-1:0]] <= cmd_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (int'(cmd_code) < NENT) begin
      rd_mux = temps[cmd_code[IW-1:0]];
    end else begin
      case (cmd_code)
        C_MAX:    rd_mux = mx_q;
        C_FW:     rd_mux = FW_VER;
        C_MAXLOC: rd_mux = DW'(mx_loc_q);
        C_ALOC:   rd_mux = DW'(aloc_q);
        default: begin
          if (cmd_code[7:2] == C_CFG0[7:2]) rd_mux = cfg[cmd_code[1:0]];
          else if ((cmd_code >= C_THR0) && (int'(cmd_code - C_THR0) < NSOCK))
            rd_mux = thr[cmd_code[SW-1:0]];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      poll_req <= 1'b0;
    end else begin
      rd_valid <= is_rd;
      if (is_rd) rd_data <= rd_mux;
      poll_req <= is_send && (cmd_code == C_POLL);
    end
  end

  assert_poll_source_R9: assert property (@(posedge clk) disable iff (rst)
    poll_req |-> $past(cmd_valid && cmd_op == 2'd2 && cmd_code == C_POLL));
  assert_rd_valid_source_R1: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(cmd_valid && cmd_op == 2'd0));
  assert_undef_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd0 && cmd_code >= C_POLL) |=> (rd_data == '0));
  assert_fw_readonly_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd0 && cmd_code == C_FW) |=> (rd_data == FW_VER));
endmodule

// File: tb/thermo_regbank_tb.sv
module thermo_regbank_tb;
  logic clk = 1'b0;
  logic rst;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [7:0] cmd_code = 0;
  logic [15:0] cmd_wdata = 0;
  logic upd_valid = 0;
  logic [1:0] upd_sock = 0;
  logic [0:0] upd_dom = 0;
  logic [15:0] upd_temp = 0;
  logic [15:0] rd_data;
  logic rd_valid, alert, poll_req;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] mt [8];
  logic [15:0] mcfg [4];
  logic [15:0] mthr [4];
  bit          malert;
  logic [15:0] mloc;

  always #5 clk = ~clk;

  thermo_regbank u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .upd_valid(upd_valid),
    .upd_sock(upd_sock), .upd_dom(upd_dom), .upd_temp(upd_temp),
    .rd_data(rd_data), .rd_valid(rd_valid), .alert(alert), .poll_req(poll_req)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_max(output logic [15:0] loc);
    logic [15:0] best = 0;
    bit found = 0;
    loc = 0;
    for (int i = 0; i < 8; i++)
      if (mcfg[0][i/2]) begin
        if (!found || $signed(mt[i]) > $signed(best)) begin
          best = mt[i];
          loc = 16'(i);
        end
        found = 1;
      end
    return best;
  endfunction

  function automatic logic [15:0] exp_read(input logic [7:0] c);
    logic [15:0] l, m;
    m = exp_max(l);
    if (c < 8) return mt[c[2:0]];
    case (c)
      8'h08: return m;
      8'h09: return 16'h0103;
      8'h0A: return l;
      8'h0B: return malert ? mloc : 16'h0;
      8'h0C, 8'h0D, 8'h0E, 8'h0F: return mcfg[c[1:0]];
      8'h10, 8'h11, 8'h12, 8'h13: return mthr[c[1:0]];
      default: return 16'h0;
    endcase
  endfunction

  function automatic void eval_alert();
    if (!malert && mcfg[0][6])
      for (int i = 0; i < 8; i++)
        if (!malert && mcfg[0][i/2] && $signed(mt[i]) > $signed(mthr[i/2])) begin
          malert = 1;
          mloc = 16'(i);
        end
  endfunction

  task automatic settle();
    repeat (2) @(negedge clk);
    eval_alert();
    check(alert == malert, "R7 alert level", 16'(alert), 16'(malert));
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [7:0] c, input logic [15:0] w);
    cmd_valid = 1; cmd_op = op; cmd_code = c; cmd_wdata = w;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic do_read(input logic [7:0] c, input string req);
    logic [15:0] e;
    e = exp_read(c);
    do_cmd(2'd0, c, 16'h0);
    check(rd_valid == 1'b1, "R1 rd_valid high", 16'(rd_valid), 16'h1);
    check(rd_data == e, req, rd_data, e);
    check(poll_req == 1'b0, "R9 read raises no poll", 16'(poll_req), 16'h0);
    @(negedge clk);
    check(rd_valid == 1'b0, "R1 rd_valid one cycle", 16'(rd_valid), 16'h0);
  endtask

  task automatic do_write(input logic [7:0] c, input logic [15:0] w);
    do_cmd(2'd1, c, w);
    if (c >= 8'h0C && c <= 8'h0F) mcfg[c[1:0]] = w;
    if (c >= 8'h10 && c <= 8'h13) mthr[c[1:0]] = w;
    settle();
  endtask

  task automatic do_send(input logic [7:0] c);
    do_cmd(2'd2, c, 16'h0);
    check(poll_req == (c == 8'h14), "R9 poll strobe", 16'(poll_req), 16'(c == 8'h14));
    @(negedge clk);
    check(poll_req == 1'b0, "R9 poll one cycle", 16'(poll_req), 16'h0);
    if (c == 8'h15) begin malert = 0; mloc = 0; end
    @(negedge clk);
    eval_alert();
    check(alert == malert, "R7 alert after send", 16'(alert), 16'(malert));
  endtask

  task automatic do_upd(input int idx, input logic [15:0] v);
    upd_valid = 1; upd_sock = 2'(idx / 2); upd_dom = 1'(idx % 2); upd_temp = v;
    @(negedge clk);
    upd_valid = 0;
    mt[idx] = v + mcfg[2];
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %h expected %h", 16'h1, 16'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < 8; i++) mt[i] = 0;
    mcfg[0] = 16'h000F; mcfg[1] = 0; mcfg[2] = 0; mcfg[3] = 0;
    for (int i = 0; i < 4; i++) mthr[i] = 16'h7FFF;
    malert = 0; mloc = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check(rd_data == 0 && rd_valid == 0, "R11 reset outputs", rd_data, 16'h0);
    check(alert == 0 && poll_req == 0, "R11 reset alert/poll", 16'({alert, poll_req}), 16'h0);
    for (int c = 0; c < 8; c++) do_read(8'(c), "R11 reset temp");
    do_read(8'h0C, "R5 cfg0 reset");
    do_read(8'h11, "R6 threshold reset");
    do_read(8'h09, "R10 firmware version");
    // R1 / R2 directed
    do_upd(5, 16'h0123);
    do_read(8'h05, "R1 read socket2 dom1");
    do_write(8'h0E, 16'hFFFD);
    do_upd(2, 16'h0001);
    do_read(8'h02, "R2 negative offset wrap");
    do_read(8'h0E, "R5 offset readback");
    // R3 / R4 signed max and ties
    do_write(8'h0E, 16'h0000);
    for (int i = 0; i < 8; i++) do_upd(i, 16'hFF00 + 16'(i));
    do_upd(3, 16'h0050);
    do_upd(6, 16'h0050);
    do_read(8'h08, "R3 signed max");
    do_read(8'h0A, "R4 max tie lowest code");
    do_write(8'h0C, 16'h0004);
    do_read(8'h08, "R3 only socket2");
    do_read(8'h0A, "R4 only socket2");
    do_write(8'h0C, 16'h0000);
    do_read(8'h08, "R3 none enabled zero");
    do_read(8'h0A, "R4 none enabled zero");
    // R7 / R8 sticky alert
    do_write(8'h0C, 16'h004F);
    do_write(8'h12, 16'h0010);
    do_read(8'h0B, "R8 loc while clear");
    do_upd(5, 16'h0020);
    check(alert == 1'b1, "R7 alert set", 16'(alert), 16'h1);
    do_read(8'h0B, "R8 alert location");
    do_upd(5, 16'h0000);
    do_upd(4, 16'hFFF0);
    check(alert == 1'b1, "R7 alert sticky", 16'(alert), 16'h1);
    do_send(8'h15);
    check(alert == 1'b0, "R7 alert cleared", 16'(alert), 16'h0);
    do_read(8'h0B, "R8 loc after clear");
    // R9
    do_send(8'h14);
    do_send(8'h33);
    // R10 ignored writes, undefined reads
    do_write(8'h00, 16'hABCD);
    do_read(8'h00, "R10 write to temp ignored");
    do_write(8'h09, 16'h5555);
    do_read(8'h09, "R10 write to version ignored");
    do_write(8'h14, 16'h1111);
    do_write(8'h20, 16'h2222);
    do_read(8'h14, "R10 read 14h zero");
    do_read(8'h1F, "R10 read undefined zero");
    do_read(8'h12, "R6 threshold kept");
    // constrained random
    for (int it = 0; it < 400; it++) begin
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0, 1, 2: do_upd($urandom_range(0, 7), 16'($urandom_range(0, 400)) - 16'd200);
        3: do_write(8'h10 + 8'($urandom_range(0, 3)), 16'($urandom_range(0, 400)) - 16'd200);
        4: do_write(8'h0C, {8'($urandom), 1'b0, 1'($urandom), 2'($urandom), 4'($urandom)});
        5: do_write(8'h0E, 16'($urandom_range(0, 16)) - 16'd8);
        6: do_send($urandom_range(0, 1) ? 8'h15 : 8'h14);
        default: do_read(8'($urandom_range(0, 31)), "R1-random read");
      endcase
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule